// File: doc/BRIEF.md
# Coprocessor Busy Stall Interlock

This block sits beside a host pipeline that drives a geometry coprocessor. Each coprocessor command takes a fixed number of cycles, and that number depends on the command. When the host hands over a command, the block looks up the command's latency from its 6-bit code. It then loads a down-counter that holds the number of cycles left before the command finishes.

While that counter is non-zero, the block raises a stall to the host on any attempt to reach the coprocessor. Such an attempt is a register read, a register write, a load into or a store from a coprocessor register, or a further command. The stall drops on exactly the cycle the previous command completes. Instructions that do not touch the coprocessor are never held.

The counter counts cycles relative to now, not an absolute deadline. Rebasing the host's cycle counter therefore needs no action here. A separate force-idle input empties the counter, for use when machine state is restored.

The host performs the memory half of a load into a coprocessor register first. It raises its access request only when the value is ready to be written into the coprocessor. The stall therefore lands on the register write and not on the memory read.

Top module: `cop_busy_interlock`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `stall` are both low.
- R2: Command latencies in cycles, by 6-bit code: 0x01=15, 0x06=8, 0x0C=6, 0x10=8, 0x11=7, 0x12=8, 0x13=19, 0x14=13, 0x16=44, 0x1B=17, 0x1C=11, 0x1E=14, 0x20=30, 0x28=5, 0x29=8, 0x2A=17, 0x2D=5, 0x2E=6, 0x30=23, 0x3D=5, 0x3E=5, 0x3F=39.
- R3: A command with latency L accepted on cycle T (`cmd_issue` high, `stall` low) leaves `busy` high on cycles T+1 through T+L and low on cycle T+L+1, so the completion deadline is T+L+1.
- R4: A register access (`cop_access_valid` high) presented on a cycle where k cycles of latency remain sees `stall` high for exactly k cycles. It proceeds on the deadline cycle.
- R5: An access or command presented while `busy` is low sees `stall` low in that same cycle, so no stall cycles are inserted.
- R6: A command presented while the previous one is still running is held by `stall` and not accepted. When a second command follows directly on the cycle after the first is accepted, it stalls for exactly the first command's latency. It starts its own latency only from its own acceptance.
- R7: Every code not listed in R2 has latency 0. Accepting such a command never raises `busy`.
- R8: `idle_force` high on a cycle empties the counter, so `busy` is low on the next cycle. It takes priority over a command accepted in the same cycle.
- R9: `stall` is low whenever neither `cop_access_valid` nor `cmd_issue` is high, even while `busy` is high.
- R10: `cop_access_valid` and `cmd_issue` are never high in the same cycle. This is a rule on the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cop_access_valid | input | 1 | Host requests a coprocessor register read, write, load or store |
| cmd_issue | input | 1 | Host presents a coprocessor command |
| cmd_code | input | 6 | Code of the presented command |
| idle_force | input | 1 | Empties the remaining-cycles counter |
| stall | output | 1 | Host must hold its coprocessor request this cycle |
| busy | output | 1 | A command is still running |

## Verification
The bench builds the block with its default 16-bit counter. With that width, every command code fits, and the whole 6-bit code space can be swept one code at a time. Each code's busy length is compared against the latency table, including the zero latency of undefined codes.

For every code, a further command follows directly, so the stall length of back-to-back commands is checked against each possible first latency. Register accesses are started at several offsets into a long command. This covers partial stalls down to a single cycle and accesses made after completion.

// File: rtl/cop_stall_pkg.sv
package cop_stall_pkg;

    localparam int CMD_W   = 6;
    localparam int TIMER_W = 16;
    localparam int LAT_W   = 8;

    typedef logic [CMD_W-1:0] cmd_code_t;
    typedef logic [LAT_W-1:0] lat_t;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_ACCESS = 2'd1,
        REQ_CMD    = 2'd2
    } req_kind_e;

    typedef struct packed {
        logic clear;
        logic load;
    } timer_ctl_t;

    function automatic lat_t cmd_latency(input cmd_code_t code);
        lat_t lat;
        case (code)
            6'h01: lat = 8'd15;
            6'h06: lat = 8'd8;
            6'h0C: lat = 8'd6;
            6'h10: lat = 8'd8;
            6'h11: lat = 8'd7;
            6'h12: lat = 8'd8;
            6'h13: lat = 8'd19;
            6'h14: lat = 8'd13;
            6'h16: lat = 8'd44;
            6'h1B: lat = 8'd17;
            6'h1C: lat = 8'd11;
            6'h1E: lat = 8'd14;
            6'h20: lat = 8'd30;
            6'h28: lat = 8'd5;
            6'h29: lat = 8'd8;
            6'h2A: lat = 8'd17;
            6'h2D: lat = 8'd5;
            6'h2E: lat = 8'd6;
            6'h30: lat = 8'd23;
            6'h3D: lat = 8'd5;
            6'h3E: lat = 8'd5;
            6'h3F: lat = 8'd39;
            default: lat = 8'd0;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/cop_lat_lookup.sv
module cop_lat_lookup
    import cop_stall_pkg::*;
#(
    parameter int W = TIMER_W
) (
    input  cmd_code_t      code,
    output logic [W-1:0]   latency
);
    localparam int PAD = (W > LAT_W) ? (W - LAT_W) : 0;

    generate
        if (W >= LAT_W) begin : g_wide
            assign latency = {{PAD{1'b0}}, cmd_latency(code)};
        end else begin : g_narrow
            assign latency = cmd_latency(code)[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cop_busy_timer.sv
module cop_busy_timer
    import cop_stall_pkg::*;
#(
    parameter int W = TIMER_W
) (
    input  logic         clk,
    input  logic         rst,
    input  timer_ctl_t   ctl,
    input  logic [W-1:0] load_val,
    output logic         running
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            remaining <= '0;
        end else if (ctl.load) begin
            remaining <= load_val;
        end else if (remaining != '0) begin
            remaining <= remaining - ONE;
        end
    end

    assign running = (remaining != '0);

    // R3
    load_takes_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !ctl.clear) |=> (remaining == $past(load_val)));

    // R3
    countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.clear && remaining != '0) |=> (remaining == $past(remaining) - ONE));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> !running);
endmodule

// File: rtl/cop_busy_interlock.sv
module cop_busy_interlock
    import cop_stall_pkg::*;
#(
    parameter int CNT_W = TIMER_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cop_access_valid,
    input  logic       cmd_issue,
    input  logic [5:0] cmd_code,
    input  logic       idle_force,
    output logic       stall,
    output logic       busy
);
    req_kind_e        req;
    timer_ctl_t       ctl;
    logic [CNT_W-1:0] cmd_lat;
    logic             running;

    always_comb begin
        if (cmd_issue)             req = REQ_CMD;
        else if (cop_access_valid) req = REQ_ACCESS;
        else                       req = REQ_IDLE;
    end

    cop_lat_lookup #(.W(CNT_W)) u_lookup (
        .code    (cmd_code),
        .latency (cmd_lat)
    );

    always_comb begin
        ctl.clear = idle_force;
        ctl.load  = (req == REQ_CMD) && !running;
    end

    cop_busy_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (cmd_lat),
        .running  (running)
    );

    assign busy  = running;
    assign stall = (req != REQ_IDLE) && running;

    // R10
    no_dual_request_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_issue && cop_access_valid));

    // R9
    stall_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (cmd_issue || cop_access_valid));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !stall));

    // R7
    zero_latency_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_issue && !stall && !idle_force && cmd_lat == '0) |=> !busy);

    // R6
    held_cmd_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_issue && stall && !idle_force && $past(busy)) |-> busy);
endmodule

// File: tb/test_cop_busy_interlock.sv
module test_cop_busy_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cop_access_valid = 1'b0;
    logic       cmd_issue = 1'b0;
    logic [5:0] cmd_code = '0;
    logic       idle_force = 1'b0;
    logic       stall;
    logic       busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_busy_interlock i_cop_busy_interlock (
        .clk              (clk),
        .rst              (rst),
        .cop_access_valid (cop_access_valid),
        .cmd_issue        (cmd_issue),
        .cmd_code         (cmd_code),
        .idle_force       (idle_force),
        .stall            (stall),
        .busy             (busy)
    );

    function automatic int exp_lat(input int c);
        case (c)
            'h01: return 15; 'h06: return 8;  'h0C: return 6;  'h10: return 8;
            'h11: return 7;  'h12: return 8;  'h13: return 19; 'h14: return 13;
            'h16: return 44; 'h1B: return 17; 'h1C: return 11; 'h1E: return 14;
            'h20: return 30; 'h28: return 5;  'h29: return 8;  'h2A: return 17;
            'h2D: return 5;  'h2E: return 6;  'h30: return 23; 'h3D: return 5;
            'h3E: return 5;  'h3F: return 39;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Called just after a falling edge; returns just after the falling edge
    // of the cycle following acceptance.
    task automatic issue_cmd(input int code, output int stalls);
        cmd_issue = 1'b1;
        cmd_code  = 6'(code);
        stalls    = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_issue = 1'b0;
    endtask

    // Counts busy cycles; also records any stall seen without a request.
    task automatic drain(output int n, output int idle_stall);
        n = 0;
        idle_stall = 0;
        #1;
        while (busy) begin
            n++;
            if (stall) idle_stall = 1;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic access(output int stalls);
        cop_access_valid = 1'b1;
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cop_access_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s, n, idle_stall, any_idle;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check("R1 busy", int'(busy), 0);
        check("R1 stall", int'(stall), 0);
        @(negedge clk);

        // R2 R3 R5 R7: sweep every code from idle
        any_idle = 0;
        for (int c = 0; c < 64; c++) begin
            issue_cmd(c, s);
            check("R5 idle cmd stall", s, 0);
            drain(n, idle_stall);
            any_idle |= idle_stall;
            if (exp_lat(c) == 0) check("R7 undefined code busy", n, 0);
            else                 check("R2 R3 busy length", n, exp_lat(c));
        end
        // R9
        check("R9 stall without request", any_idle, 0);

        // R6: back-to-back commands for every first code
        for (int c = 0; c < 64; c++) begin
            issue_cmd(c, s);
            issue_cmd((c * 7 + 1) % 64, s);
            check("R6 back-to-back stall", s, exp_lat(c));
            drain(n, idle_stall);
            check("R6 second latency", n, exp_lat((c * 7 + 1) % 64));
        end

        // R4: access at several offsets into a 44-cycle command
        for (int k = 0; k <= 46; k += 3) begin
            issue_cmd('h16, s);
            repeat (k) @(negedge clk);
            access(s);
            check("R4 access stall", s, (44 - k > 0) ? 44 - k : 0);
            drain(n, idle_stall);
        end
        // R4: last cycle exactly
        issue_cmd('h28, s);
        repeat (4) @(negedge clk);
        access(s);
        check("R4 one remaining", s, 1);
        drain(n, idle_stall);

        // R5: access while idle
        access(s);
        check("R5 idle access", s, 0);

        // R8: force idle mid-command
        issue_cmd('h3F, s);
        idle_force = 1'b1;
        @(negedge clk);
        idle_force = 1'b0;
        #1;
        check("R8 busy after clear", int'(busy), 0);
        @(negedge clk);
        access(s);
        check("R8 access after clear", s, 0);

        // R8: clear beats a same-cycle accepted command
        cmd_issue  = 1'b1;
        cmd_code   = 6'h16;
        idle_force = 1'b1;
        @(negedge clk);
        cmd_issue  = 1'b0;
        idle_force = 1'b0;
        #1;
        check("R8 clear priority", int'(busy), 0);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule